// File: doc/BRIEF.md
# Unprivileged Timer Access Trap Checker

This block sits beside the timer and counter register file and rules on each access to it. For every access it looks at the current privilege level, which register is being touched and whether the access is a read or a write. It then decides whether the access may go ahead or must raise an undefined-instruction trap. The decision uses four permission bits held in a 32-bit kernel timer control word. That word is stored inside this block.

The control word is reachable only from privilege levels 1 to 3. At those levels a read returns all 32 bits, and a write raises a write enable and loads the word at the next clock edge. Level 0 code is the only code that the permission bits restrict. At level 0 the frequency register has a looser rule than the counters: it stays open while either counter permission bit is set. The trap, the read data and the write enable are combinational. They are formed from the registered word and the access inputs in the same cycle.

Top module: `timer_access_trap`

## Requirements
- R1: After reset the control word holds CTL_RST (default all zeros). A read of it from level 1 returns that value.
- R2: At level 0, an access to the physical timer control, compare or value register (ids 4, 5, 6) traps exactly when control bit 9 is 0.
- R3: At level 0, an access to the virtual timer control, compare or value register (ids 7, 8, 9) traps exactly when control bit 8 is 0.
- R4: At level 0, an access to the virtual count (id 3) traps exactly when control bit 1 is 0.
- R5: At level 0, an access to the physical count (id 2) traps exactly when control bit 0 is 0.
- R6: At level 0, an access to the frequency register (id 1) traps only when control bits 0 and 1 are both 0.
- R7: At level 0, any access to the control word (id 0) traps. It gives zero read data and no write enable, and the stored word does not change.
- R8: At levels 1, 2 and 3 no access traps. A read of id 0 returns the full 32-bit word. A write of id 0 asserts ctl_we_o in that cycle, and the new value is read back from the next cycle on.
- R9: Register ids 10 to 15 never trap, at any level and for any control value.
- R10: With acc_valid_i low, trap_o and ctl_we_o are 0 and rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| priv_i | input | 2 | Current privilege level, 0 to 3 |
| reg_id_i | input | 4 | Register identifier (0 control word, 1 frequency, 2 physical count, 3 virtual count, 4-6 physical timer, 7-9 virtual timer) |
| wr_i | input | 1 | 1 for write, 0 for read |
| wdata_i | input | 32 | Write data for the control word |
| trap_o | output | 1 | Raise an undefined-instruction trap |
| ctl_we_o | output | 1 | Allowed write to the control word this cycle |
| rdata_o | output | 32 | Control word read data, zero unless an allowed read |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a zero reset value and permission bits at positions 0, 1, 8 and 9. These defaults let the bench drive each permission pattern, one bit at a time, the bit pairs and the full word, through allowed level 1 writes. Under each pattern it sweeps all sixteen register ids at every privilege level, for both reads and writes. Because of this sweep, the rule for the frequency register, the unlisted ids and the attempted level 0 writes to the control word are all seen against each permission pattern.

// File: rtl/timer_trap_pkg.sv
package timer_trap_pkg;
  localparam int REG_ID_W = 4;

  typedef enum logic [REG_ID_W-1:0] {
    REG_CTL    = 4'd0,
    REG_FREQ   = 4'd1,
    REG_PCNT   = 4'd2,
    REG_VCNT   = 4'd3,
    REG_PT_CTL = 4'd4,
    REG_PT_CMP = 4'd5,
    REG_PT_VAL = 4'd6,
    REG_VT_CTL = 4'd7,
    REG_VT_CMP = 4'd8,
    REG_VT_VAL = 4'd9
  } reg_id_e;

  localparam logic [REG_ID_W-1:0] LAST_LISTED = REG_VT_VAL;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_CTL, CLS_FREQ, CLS_PCNT, CLS_VCNT, CLS_PTMR, CLS_VTMR
  } reg_cls_e;

  typedef struct packed {
    logic ptmr;
    logic vtmr;
    logic vcnt;
    logic pcnt;
  } perm_t;
endpackage

// File: rtl/tat_reg_classify.sv
module tat_reg_classify
  import timer_trap_pkg::*;
(
  input  logic [REG_ID_W-1:0] reg_id_i,
  output reg_cls_e            cls_o
);
  always_comb begin
    unique case (reg_id_i)
      REG_CTL:                            cls_o = CLS_CTL;
      REG_FREQ:                           cls_o = CLS_FREQ;
      REG_PCNT:                           cls_o = CLS_PCNT;
      REG_VCNT:                           cls_o = CLS_VCNT;
      REG_PT_CTL, REG_PT_CMP, REG_PT_VAL: cls_o = CLS_PTMR;
      REG_VT_CTL, REG_VT_CMP, REG_VT_VAL: cls_o = CLS_VTMR;
      default:                            cls_o = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/tat_trap_decide.sv
module tat_trap_decide
  import timer_trap_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] priv_i,
  input  reg_cls_e   cls_i,
  input  perm_t      perm_i,
  output logic       trap_o,
  output logic       ctl_open_o
);
  logic user_lvl;
  assign user_lvl = (priv_i == 2'd0);

  always_comb begin
    trap_o = 1'b0;
    if (valid_i && user_lvl) begin
      unique case (cls_i)
        CLS_CTL:  trap_o = 1'b1;
        // frequency stays open while either counter is open
        CLS_FREQ: trap_o = ~(perm_i.pcnt | perm_i.vcnt);
        CLS_PCNT: trap_o = ~perm_i.pcnt;
        CLS_VCNT: trap_o = ~perm_i.vcnt;
        CLS_PTMR: trap_o = ~perm_i.ptmr;
        CLS_VTMR: trap_o = ~perm_i.vtmr;
        default:  trap_o = 1'b0;
      endcase
    end
  end

  assign ctl_open_o = valid_i && !user_lvl && (cls_i == CLS_CTL);
endmodule

// File: rtl/tat_ctl_store.sv
module tat_ctl_store #(
  parameter int               DATA_W  = 32,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= wdata_i;
  end

  p_hold_no_we_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/timer_access_trap.sv
module timer_access_trap
  import timer_trap_pkg::*;
#(
  parameter int               DATA_W  = 32,
  parameter logic [DATA_W-1:0] CTL_RST = '0,
  parameter int               PC_BIT  = 0,
  parameter int               VC_BIT  = 1,
  parameter int               VT_BIT  = 8,
  parameter int               PT_BIT  = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_valid_i,
  input  logic [1:0]          priv_i,
  input  logic [REG_ID_W-1:0] reg_id_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                trap_o,
  output logic                ctl_we_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0] ctl_q;
  perm_t             perm;
  reg_cls_e          cls;
  logic              ctl_open;

  assign perm.pcnt = ctl_q[PC_BIT];
  assign perm.vcnt = ctl_q[VC_BIT];
  assign perm.vtmr = ctl_q[VT_BIT];
  assign perm.ptmr = ctl_q[PT_BIT];

  tat_reg_classify u_cls (
    .reg_id_i (reg_id_i),
    .cls_o    (cls)
  );

  tat_trap_decide u_dec (
    .valid_i    (acc_valid_i),
    .priv_i     (priv_i),
    .cls_i      (cls),
    .perm_i     (perm),
    .trap_o     (trap_o),
    .ctl_open_o (ctl_open)
  );

  assign ctl_we_o = ctl_open && wr_i;
  assign rdata_o  = (ctl_open && !wr_i) ? ctl_q : '0;

  tat_ctl_store #(.DATA_W(DATA_W), .RST_VAL(CTL_RST)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_o),
    .wdata_i (wdata_i),
    .q_o     (ctl_q)
  );

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!trap_o && !ctl_we_o && rdata_o == '0));
  p_upper_no_trap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && priv_i != 2'd0) |-> !trap_o);
  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_o |=> (ctl_q == $past(wdata_i)));
  p_user_ctl_trap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && priv_i == 2'd0 && reg_id_i == REG_CTL)
      |-> (trap_o && !ctl_we_o && rdata_o == '0));
  p_freq_open_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && reg_id_i == REG_FREQ && (ctl_q[PC_BIT] || ctl_q[VC_BIT])) |-> !trap_o);
  p_unlisted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_id_i > LAST_LISTED) |-> !trap_o);
endmodule

// File: tb/sim_timer_access_trap.sv
`timescale 1ns/1ps
module sim_timer_access_trap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  priv = '0;
  logic [3:0]  rid = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        trap, we;
  logic [31:0] rdata;

  always #4 clk = ~clk;

  timer_access_trap u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .priv_i(priv),
    .reg_id_i(rid), .wr_i(wr), .wdata_i(wdata),
    .trap_o(trap), .ctl_we_o(we), .rdata_o(rdata)
  );

  int checks = 0;
  int bad = 0;
  logic [33:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_ctl = '0;
  bit          done = 1'b0;

  function automatic logic exp_trap(logic [1:0] p, logic [3:0] id, logic [31:0] c);
    if (p != 2'd0) return 1'b0;
    case (id)
      4'd0:             return 1'b1;
      4'd1:             return !(c[0] | c[1]);
      4'd2:             return !c[0];
      4'd3:             return !c[1];
      4'd4, 4'd5, 4'd6: return !c[9];
      4'd7, 4'd8, 4'd9: return !c[8];
      default:          return 1'b0;
    endcase
  endfunction

  function automatic string pick_tag(logic [1:0] p, logic [3:0] id);
    if (id > 4'd9) return "R9";
    if (p != 2'd0) return "R8";
    case (id)
      4'd0:             return "R7";
      4'd1:             return "R6";
      4'd2:             return "R5";
      4'd3:             return "R4";
      4'd4, 4'd5, 4'd6: return "R2";
      default:          return "R3";
    endcase
  endfunction

  task automatic access(input logic [1:0] p, input logic [3:0] id, input logic w,
                        input logic [31:0] d, input string tg);
    logic        e_we;
    logic [31:0] e_rd;
    @(negedge clk);
    valid = 1'b1; priv = p; rid = id; wr = w; wdata = d;
    e_we = (p != 2'd0) && (id == 4'd0) && w;
    e_rd = ((p != 2'd0) && (id == 4'd0) && !w) ? m_ctl : '0;
    exp_q.push_back({exp_trap(p, id, m_ctl), e_we, e_rd});
    tag_q.push_back(tg == "" ? pick_tag(p, id) : tg);
    if (e_we) m_ctl = d;
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; priv = 2'd0; rid = 4'd0; wr = 1'b1; wdata = 32'hFFFF_FFFF;
    exp_q.push_back('0);
    tag_q.push_back("R10");
  endtask

  // monitor: compare outputs mid-low-phase against the queued expectation
  initial forever begin
    @(negedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic [33:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({trap, we, rdata} !== e) begin
        bad++;
        $display("FAIL %s: got trap=%b we=%b rdata=%h exp trap=%b we=%b rdata=%h",
                 t, trap, we, rdata, e[33], e[32], e[31:0]);
      end
    end
  end

  task automatic sweep();
    for (int p = 0; p < 4; p++)
      for (int id = 0; id < 16; id++) begin
        access(2'(p), 4'(id), 1'b0, '0, "");
        if (p == 0 || id != 0) access(2'(p), 4'(id), 1'b1, 32'hDEAD_BEEF, "");
      end
  endtask

  initial begin
    logic [31:0] pats [10];
    pats = '{32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0100,
             32'h0000_0200, 32'h0000_0303, 32'hFFFF_FCFC, 32'hFFFF_FFFF,
             32'hA5A5_5A5A, 32'h0000_0000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    access(2'd1, 4'd0, 1'b0, '0, "R1");
    idle();
    sweep();
    foreach (pats[i]) begin
      access(2'(1 + (i % 3)), 4'd0, 1'b1, pats[i], "R8");
      access(2'd2, 4'd0, 1'b0, '0, "R8");
      access(2'd0, 4'd0, 1'b1, ~pats[i], "R7");
      access(2'd3, 4'd0, 1'b0, '0, "R7");
      idle();
      sweep();
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule